// File: doc/BRIEF.md
# Chamber Hit Multiplicity Threshold Encoder

The encoder takes one 16-bit word of trigger bits per clock from each of twelve chamber fiber channels and reduces every chamber to two results. The first is the number of hits that survive filtering, on 5 bits. The second is a 2-bit level code that grades that number against three programmable thresholds. Every channel has its own identical pipeline. A bit counts only if it stays high for two consecutive cycles, so single-cycle glitches are removed. After that, a per-bit blocking mask removes known noisy strips. The surviving bits are counted and the count is graded. Results appear three clock edges after the word was sampled, and a valid flag travels alongside them.

Each channel can be switched off; a switched-off channel reports zero hits and level code 0. The thresholds must be strictly ordered above zero and below 16. A small two-state guard watches them. In state `CFG_GOOD` the thresholds are ordered, and the guard moves to `CFG_FAULT` as soon as they are not. In `CFG_FAULT` the error output is raised and every level code is held at 0; the guard returns to `CFG_GOOD` once the ordering holds again. Hit counts are unaffected by the guard.

Top module: `chamber_mult_encoder`

## Requirements
- R1: A bit of a channel's word takes part in the count only when it was 1 in both the word sampled at that edge and the word sampled at the edge before; a bit high for a single cycle is never counted.
- R2: Setting `bit_block[c*16+i]` to 1 excludes bit i of channel c from the count, whatever the input.
- R3: `out_mult[c*5 +: 5]` carries the number of filtered, unblocked bits of channel c, from 0 to 16.
- R4: `out_level[c*2 +: 2]` is 0 when the count is below `thr_lo`, 1 when it is at least `thr_lo`, 2 when it is at least `thr_mid`, and 3 when it is at least `thr_hi`.
- R5: When `ch_enable[c]` is 0, channel c outputs multiplicity 0 and level code 0.
- R6: Unless 0 < `thr_lo` < `thr_mid` < `thr_hi` < 16, `config_error` is 1 from the next edge on and every level code is 0; multiplicity outputs are not affected.
- R7: A word sampled at clock edge k produces its results at edge k+3, and `out_valid` at edge k+3 equals `in_valid` sampled at edge k.
- R8: While `rst_n` is low, all outputs are 0.
- R9: Each channel's results depend only on its own word, mask bits and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks the input words as meaningful |
| in_words | input | 192 | Trigger words, channel c at bits c*16 +: 16 |
| bit_block | input | 192 | Per-bit exclusion mask, 1 = bit ignored |
| ch_enable | input | 12 | Per-channel enable, 1 = active |
| thr_lo | input | 5 | Lowest threshold |
| thr_mid | input | 5 | Middle threshold |
| thr_hi | input | 5 | Highest threshold |
| out_valid | output | 1 | `in_valid` delayed by three edges |
| out_mult | output | 60 | Hit count per channel, channel c at bits c*5 +: 5 |
| out_level | output | 24 | Level code per channel, channel c at bits c*2 +: 2 |
| config_error | output | 1 | Threshold ordering is violated |

## Verification
The hardest situation to reach is the grading boundary at every threshold position. Here the count equals a threshold exactly, while the glitch filter and the mask are also shaping which bits survive. The bench sweeps all 455 strictly ordered threshold triples and, for each one, streams words that change every cycle. The expected count is therefore the overlap of two successive words minus blocked bits. A second phase holds words for two cycles at graded hit counts from 0 to 16, so every count value lands on each boundary.

// File: rtl/mtenc_pkg.sv
package mtenc_pkg;
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_HIGH = 2'd3
    } level_t;

    typedef enum logic {
        CFG_GOOD  = 1'b0,
        CFG_FAULT = 1'b1
    } cfg_state_t;
endpackage

// File: rtl/mtenc_glitch.sv
module mtenc_glitch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] filt_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] filt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            filt_q <= '0;
        end else begin
            prev_q <= raw_i;
            filt_q <= raw_i & prev_q;
        end
    end

    assign filt_o = filt_q;

    assert_filter_needs_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q & ~$past(raw_i)) == '0);
endmodule

// File: rtl/mtenc_count.sv
module mtenc_count #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  bits_i,
    input  logic [W-1:0]  block_i,
    output logic [CW-1:0] cnt_o
);
    logic [W-1:0]  live;
    logic [CW-1:0] sum;
    logic [CW-1:0] cnt_q;

    always_comb begin
        live = bits_i & ~block_i;
        sum  = '0;
        for (int i = 0; i < W; i++) begin
            sum = sum + CW'(live[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= sum;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/mtenc_grade.sv
module mtenc_grade
    import mtenc_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          en_i,
    input  logic          cfg_bad_i,
    input  logic [CW-1:0] thr_lo_i,
    input  logic [CW-1:0] thr_mid_i,
    input  logic [CW-1:0] thr_hi_i,
    output logic [CW-1:0] mult_o,
    output logic [1:0]    level_o
);
    level_t        level_d;
    level_t        level_q;
    logic [CW-1:0] mult_q;

    always_comb begin
        if (!en_i || cfg_bad_i)      level_d = LVL_NONE;
        else if (cnt_i >= thr_hi_i)  level_d = LVL_HIGH;
        else if (cnt_i >= thr_mid_i) level_d = LVL_MID;
        else if (cnt_i >= thr_lo_i)  level_d = LVL_LOW;
        else                         level_d = LVL_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q  <= '0;
            level_q <= LVL_NONE;
        end else begin
            mult_q  <= en_i ? cnt_i : '0;
            level_q <= level_d;
        end
    end

    assign mult_o  = mult_q;
    assign level_o = level_q;

    assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (mult_q == '0 && level_q == LVL_NONE));
    assert_fault_blanks_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad_i |=> level_q == LVL_NONE);
    assert_level_needs_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_q != LVL_NONE |-> mult_q != '0);
endmodule

// File: rtl/mtenc_cfg_guard.sv
module mtenc_cfg_guard
    import mtenc_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] thr_lo_i,
    input  logic [CW-1:0] thr_mid_i,
    input  logic [CW-1:0] thr_hi_i,
    output logic          bad_o,
    output logic          fault_o
);
    localparam logic [CW-1:0] THR_LIMIT = CW'(W);

    cfg_state_t state_q;
    cfg_state_t state_d;
    logic       ordered;

    assign ordered = (thr_lo_i != '0) && (thr_lo_i < thr_mid_i) &&
                     (thr_mid_i < thr_hi_i) && (thr_hi_i < THR_LIMIT);
    assign bad_o   = !ordered;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_GOOD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CFG_GOOD:  state_d = ordered ? CFG_GOOD : CFG_FAULT;
            CFG_FAULT: state_d = ordered ? CFG_GOOD : CFG_FAULT;
        endcase
    end

    always_comb begin
        fault_o = (state_q == CFG_FAULT);
    end
endmodule

// File: rtl/chamber_mult_encoder.sv
module chamber_mult_encoder
    import mtenc_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int WORD_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [NUM_CH*WORD_W-1:0]               in_words,
    input  logic [NUM_CH*WORD_W-1:0]               bit_block,
    input  logic [NUM_CH-1:0]                      ch_enable,
    input  logic [$clog2(WORD_W+1)-1:0]            thr_lo,
    input  logic [$clog2(WORD_W+1)-1:0]            thr_mid,
    input  logic [$clog2(WORD_W+1)-1:0]            thr_hi,
    output logic                                   out_valid,
    output logic [NUM_CH*$clog2(WORD_W+1)-1:0]     out_mult,
    output logic [NUM_CH*2-1:0]                    out_level,
    output logic                                   config_error
);
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int LAT    = 3;

    logic           cfg_bad;
    logic [LAT-1:0] vpipe_q;
    logic [1:0]     settle_q;

    mtenc_cfg_guard #(.W(WORD_W), .CW(CNT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_lo_i (thr_lo),
        .thr_mid_i(thr_mid),
        .thr_hi_i (thr_hi),
        .bad_o    (cfg_bad),
        .fault_o  (config_error)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WORD_W-1:0] filt;
        logic [CNT_W-1:0]  cnt;

        mtenc_glitch #(.W(WORD_W)) u_glitch (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (in_words[c*WORD_W +: WORD_W]),
            .filt_o(filt)
        );

        mtenc_count #(.W(WORD_W), .CW(CNT_W)) u_count (
            .clk    (clk),
            .rst_n  (rst_n),
            .bits_i (filt),
            .block_i(bit_block[c*WORD_W +: WORD_W]),
            .cnt_o  (cnt)
        );

        mtenc_grade #(.CW(CNT_W)) u_grade (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (cnt),
            .en_i     (ch_enable[c]),
            .cfg_bad_i(cfg_bad),
            .thr_lo_i (thr_lo),
            .thr_mid_i(thr_mid),
            .thr_hi_i (thr_hi),
            .mult_o   (out_mult[c*CNT_W +: CNT_W]),
            .level_o  (out_level[c*2 +: 2])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe_q  <= '0;
            settle_q <= '0;
        end else begin
            vpipe_q  <= {vpipe_q[LAT-2:0], in_valid};
            settle_q <= (settle_q == 2'd3) ? settle_q : settle_q + 2'd1;
        end
    end

    assign out_valid = vpipe_q[LAT-1];

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        settle_q == 2'd3 |-> out_valid == $past(in_valid, 3));
endmodule

// File: tb/chamber_mult_encoder_test.sv
module chamber_mult_encoder_test;
    localparam int NC = 12;
    localparam int WW = 16;
    localparam int CW = 5;
    localparam int TOT = NC * WW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [TOT-1:0] in_words = '0;
    logic [TOT-1:0] bit_block = '0;
    logic [NC-1:0]  ch_enable = '1;
    logic [CW-1:0]  thr_lo = 5'd4;
    logic [CW-1:0]  thr_mid = 5'd8;
    logic [CW-1:0]  thr_hi = 5'd12;
    logic           out_valid;
    logic [NC*CW-1:0] out_mult;
    logic [NC*2-1:0]  out_level;
    logic           config_error;

    int checks = 0;
    int failures = 0;
    int skip = 0;
    logic [31:0] seed = 32'h1ACE_B00C;
    logic [TOT-1:0] h1 = '0, h2 = '0, h3 = '0, h4 = '0;
    logic v1 = 0, v2 = 0, v3 = 0;

    chamber_mult_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
        .bit_block(bit_block), .ch_enable(ch_enable), .thr_lo(thr_lo),
        .thr_mid(thr_mid), .thr_hi(thr_hi), .out_valid(out_valid),
        .out_mult(out_mult), .out_level(out_level), .config_error(config_error)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [TOT-1:0] rnd_word();
        logic [TOT-1:0] w;
        for (int i = 0; i < TOT / 32; i++) w[i*32 +: 32] = rnd();
        return w;
    endfunction

    task automatic expect_eq(input string tag, input int act, input int exp, input int ch);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s ch=%0d actual=%0d expected=%0d", tag, ch, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic bad;
        bad = !(thr_lo != 0 && thr_lo < thr_mid && thr_mid < thr_hi && thr_hi < 16);
        expect_eq("R7 out_valid", int'(out_valid), int'(v3), -1);
        expect_eq("R6 config_error", int'(config_error), int'(bad), -1);
        for (int c = 0; c < NC; c++) begin
            logic [WW-1:0] f;
            int k, em, el;
            f = h3[c*WW +: WW] & h4[c*WW +: WW] & ~bit_block[c*WW +: WW];
            k = $countones(f);
            em = ch_enable[c] ? k : 0;
            if (!ch_enable[c] || bad) el = 0;
            else if (k >= int'(thr_hi)) el = 3;
            else if (k >= int'(thr_mid)) el = 2;
            else if (k >= int'(thr_lo)) el = 1;
            else el = 0;
            expect_eq({tag, " mult"}, int'(out_mult[c*CW +: CW]), em, c);
            expect_eq({tag, " level"}, int'(out_level[c*2 +: 2]), el, c);
        end
    endtask

    task automatic step(input string tag, input logic [TOT-1:0] w, input logic v);
        @(negedge clk);
        if (skip > 0) skip--;
        else check_outputs(tag);
        in_words = w;
        in_valid = v;
        h4 = h3; h3 = h2; h2 = h1; h1 = w;
        v3 = v2; v2 = v1; v1 = v;
    endtask

    task automatic random_steps(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, rnd_word(), rnd() [0]);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: outputs stay zero under reset while inputs are busy
        in_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_words = rnd_word();
            expect_eq("R8 reset valid", int'(out_valid), 0, -1);
            expect_eq("R8 reset mult", int'(out_mult != '0), 0, -1);
            expect_eq("R8 reset level", int'(out_level != '0), 0, -1);
            expect_eq("R8 reset cfg", int'(config_error), 0, -1);
        end
        @(negedge clk);
        in_words = '0;
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3 R4: graded hit counts, each word held two cycles so the filter passes it
        for (int j = 0; j < 40; j++) begin
            logic [TOT-1:0] w;
            for (int c = 0; c < NC; c++) begin
                int k;
                k = (j + c) % 17;
                w[c*WW +: WW] = (k == 16) ? 16'hFFFF : WW'((32'd1 << k) - 1) << (c % 3);
                if (k == 16) w[c*WW +: WW] = 16'hFFFF;
                else if ((c % 3) + k > 16) w[c*WW +: WW] = WW'((32'd1 << k) - 1);
            end
            step("R3R4", w, 1'b1);
            step("R4", w, 1'b1);
        end

        // R1 R9: words change every cycle, independent per channel
        random_steps("R1", 60);
        random_steps("R9", 40);

        // R2: blocking masks
        for (int m = 0; m < 6; m++) begin
            bit_block = (m == 5) ? '1 : rnd_word();
            skip = 3;
            random_steps("R2", 20);
        end
        bit_block = '0;

        // R5: channel enables
        for (int m = 0; m < 5; m++) begin
            ch_enable = (m == 0) ? 12'h000 : (m == 1) ? 12'hA5A : NC'(rnd());
            skip = 3;
            random_steps("R5", 20);
        end
        ch_enable = '1;

        // R6: threshold orderings that break the rule
        for (int m = 0; m < 7; m++) begin
            case (m)
                0: begin thr_lo = 0;  thr_mid = 4; thr_hi = 8;  end
                1: begin thr_lo = 5;  thr_mid = 5; thr_hi = 9;  end
                2: begin thr_lo = 3;  thr_mid = 9; thr_hi = 16; end
                3: begin thr_lo = 12; thr_mid = 8; thr_hi = 4;  end
                4: begin thr_lo = 2;  thr_mid = 7; thr_hi = 7;  end
                5: begin thr_lo = 31; thr_mid = 1; thr_hi = 2;  end
                default: begin thr_lo = 1; thr_mid = 2; thr_hi = 15; end
            endcase
            skip = 3;
            random_steps("R6", 15);
        end

        // R4 R7: every ordered triple of thresholds
        for (int a = 1; a < 14; a++)
            for (int b = a + 1; b < 15; b++)
                for (int c = b + 1; c < 16; c++) begin
                    thr_lo = CW'(a); thr_mid = CW'(b); thr_hi = CW'(c);
                    skip = 3;
                    random_steps("R4", 8);
                end
        random_steps("R7", 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule